// File: doc/BRIEF.md
# Interrupt Routing Controller

This block collects 32 level-sensitive interrupt lines and steers each onto one of 15 interrupt outputs. Software reaches it through a plain 32-bit register port with a write strobe, a byte address and a read data bus that follows the address without a wait cycle. There is one enable mask word and one read-only word that shows the synchronized input levels. Four routing words each hold eight 4-bit route codes, and each code picks the output for one input.

An input drives its chosen output only while its synchronized level is high and its enable bit is set. Each output is the OR of every input that meets these conditions and is routed to it. The outputs are registered. A host interrupt line tied to an output therefore stays high until every contributing source has dropped or has been masked. A route code can name only one output, so an input can never reach two outputs at once.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset the enable mask and all four routing words read 0, and `irqOut` is 0.
- R2: The enable mask is at offset 0x00. Bit n enables input n. A write stores the whole word and a read returns it.
- R3: Offset 0x04 reads the input levels after a two-flop synchronizer. A change on `irqIn` shows there after the second rising edge. Writes to 0x04 change nothing.
- R4: The routing words are at offsets 0x08, 0x0C, 0x10 and 0x14. Each is written and read back as a whole 32-bit word.
- R5: The route code of input n sits in the word at offset 0x08 + 4*(3 - n/8), in bits [(n mod 8)*4 +: 4]. So inputs 24..31 are at 0x08 and inputs 0..7 are at 0x14.
- R6: Route code 0 connects an input to no output. A code k from 1 to 15 connects it to output k-1, so code 15 drives output 14.
- R7: An input whose enable bit is 0 does not affect any output, whatever its level and route.
- R8: Output k is high when at least one input is synchronized high, enabled and routed to k. It stays high while any such input remains, and falls once none remains.
- R9: `irqOut` is registered. It reflects mask, route and status values one edge after they change. A change on `irqIn` therefore reaches `irqOut` on the third rising edge.
- R10: Reads of any other offset return 0, including offsets that are not word aligned. Writes to such offsets change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | 32 | Level-sensitive interrupt sources |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data for `regAddr` |
| irqOut | output | 15 | Routed interrupt outputs |

## Verification
The bench aims at the field placement, which is reversed across the routing words. A design that packed the words in forward order would send input 0 to the output chosen for input 24. Route codes 0 and 15 are exercised: an off-by-one decode would either connect a disconnected source or leave output 14 dead. Two sources share one output and are dropped one at a time, which catches an output that is edge-triggered or that tracks only the last source. The bench counts edges to check the three-cycle input latency and the one-cycle mask latency. It also writes to the status word and to unaligned and unmapped offsets, which exposes a decoder that aliases those writes onto the mask or routing words.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int OFS_MASK   = 'h00;
  localparam int OFS_STATUS = 'h04;
  localparam int OFS_ROUTE  = 'h08;
  localparam int IDX_W      = 4;

  typedef enum logic [1:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_STATUS,
    SEL_ROUTE
  } rdSel_e;

  typedef struct packed {
    logic             maskWe;
    logic             routeWe;
    logic [IDX_W-1:0] routeIdx;
    rdSel_e           rdSel;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_route_decode.sv
module irq_route_decode
  import irq_route_pkg::*;
#(
  parameter int ADDR_W         = 8,
  parameter int NUM_ROUTE_REGS = 4
) (
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobe_t       strobe
);
  localparam int ROUTE_END = OFS_ROUTE + 4 * NUM_ROUTE_REGS;

  logic              isMask;
  logic              isStatus;
  logic              isRoute;
  logic [ADDR_W-1:0] routeOfs;

  assign isMask   = (regAddr == ADDR_W'(OFS_MASK));
  assign isStatus = (regAddr == ADDR_W'(OFS_STATUS));
  assign isRoute  = (regAddr[1:0] == 2'b00) &&
                    (regAddr >= ADDR_W'(OFS_ROUTE)) &&
                    (regAddr <  ADDR_W'(ROUTE_END));
  assign routeOfs = regAddr - ADDR_W'(OFS_ROUTE);

  always_comb begin
    strobe          = '0;
    strobe.rdSel    = SEL_NONE;
    strobe.routeIdx = IDX_W'(routeOfs >> 2);
    if (isMask) begin
      strobe.rdSel  = SEL_MASK;
      strobe.maskWe = regWe;
    end else if (isStatus) begin
      strobe.rdSel  = SEL_STATUS;
    end else if (isRoute) begin
      strobe.rdSel   = SEL_ROUTE;
      strobe.routeWe = regWe;
    end
  end
endmodule

// File: rtl/irq_route_datapath.sv
module irq_route_datapath
  import irq_route_pkg::*;
#(
  parameter int NUM_IN         = 32,
  parameter int NUM_OUT        = 15,
  parameter int CODE_W         = 4,
  parameter int DATA_W         = 32,
  parameter int NUM_ROUTE_REGS = 4,
  parameter int SYNC_STAGES    = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [NUM_IN-1:0]                  irqIn,
  input  ctrlStrobe_t                        strobe,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [DATA_W-1:0]                  rdata,
  output logic [NUM_OUT-1:0]                 irqOut,
  output logic [NUM_IN-1:0]                  maskQ,
  output logic [NUM_IN-1:0]                  statusQ,
  output logic [NUM_ROUTE_REGS*DATA_W-1:0]   routeFlat
);
  localparam int FIELDS_PER_REG = DATA_W / CODE_W;

  logic [NUM_IN-1:0] syncQ [SYNC_STAGES];
  logic [DATA_W-1:0] routeQ [NUM_ROUTE_REGS];
  logic [NUM_IN-1:0][CODE_W-1:0]  codeOf;
  logic [NUM_OUT-1:0][NUM_IN-1:0] hitMat;
  logic [NUM_IN-1:0]  pending;
  logic [NUM_OUT-1:0] outNext;

  // input synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ[0] <= '0;
    else       syncQ[0] <= irqIn;
  end
  for (genvar s = 1; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) syncQ[s] <= '0;
      else       syncQ[s] <= syncQ[s-1];
    end
  end
  assign statusQ = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             maskQ <= '0;
    else if (strobe.maskWe) maskQ <= wdata[NUM_IN-1:0];
  end

  for (genvar r = 0; r < NUM_ROUTE_REGS; r++) begin : g_route
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        routeQ[r] <= '0;
      else if (strobe.routeWe && (strobe.routeIdx == IDX_W'(r)))
        routeQ[r] <= wdata;
    end
    assign routeFlat[r*DATA_W +: DATA_W] = routeQ[r];
  end

  // route fields: reversed word order, ascending fields inside a word
  for (genvar n = 0; n < NUM_IN; n++) begin : g_field
    localparam int WORD = NUM_ROUTE_REGS - 1 - n / FIELDS_PER_REG;
    localparam int LSB  = (n % FIELDS_PER_REG) * CODE_W;
    assign codeOf[n] = routeQ[WORD][LSB +: CODE_W];
  end

  assign pending = statusQ & maskQ;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    for (genvar n = 0; n < NUM_IN; n++) begin : g_hit
      assign hitMat[k][n] = (codeOf[n] == CODE_W'(k + 1));
    end
    assign outNext[k] = |(pending & hitMat[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= '0;
    else       irqOut <= outNext;
  end

  always_comb begin
    rdata = '0;
    unique case (strobe.rdSel)
      SEL_MASK:   rdata[NUM_IN-1:0] = maskQ;
      SEL_STATUS: rdata[NUM_IN-1:0] = statusQ;
      SEL_ROUTE:  rdata = routeQ[strobe.routeIdx[$clog2(NUM_ROUTE_REGS)-1:0]];
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_IN      = 32,
  parameter int NUM_OUT     = 15,
  parameter int CODE_W      = 4,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] irqIn,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [NUM_OUT-1:0] irqOut
);
  localparam int NUM_ROUTE_REGS = NUM_IN * CODE_W / DATA_W;

  ctrlStrobe_t                     strobe;
  logic [NUM_IN-1:0]               maskQ;
  logic [NUM_IN-1:0]               statusQ;
  logic [NUM_ROUTE_REGS*DATA_W-1:0] routeFlat;

  irq_route_decode #(
    .ADDR_W(ADDR_W), .NUM_ROUTE_REGS(NUM_ROUTE_REGS)
  ) u_dec (
    .regWe(regWe), .regAddr(regAddr), .strobe(strobe)
  );

  irq_route_datapath #(
    .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .CODE_W(CODE_W), .DATA_W(DATA_W),
    .NUM_ROUTE_REGS(NUM_ROUTE_REGS), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .strobe(strobe),
    .wdata(regWdata), .rdata(regRdata), .irqOut(irqOut),
    .maskQ(maskQ), .statusQ(statusQ), .routeFlat(routeFlat)
  );
endmodule

// File: rtl/irq_route_checker.sv
module irq_route_checker #(
  parameter int NUM_IN         = 32,
  parameter int NUM_OUT        = 15,
  parameter int DATA_W         = 32,
  parameter int ADDR_W         = 8,
  parameter int NUM_ROUTE_REGS = 4
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             regWe,
  input logic [ADDR_W-1:0]                regAddr,
  input logic [DATA_W-1:0]                regWdata,
  input logic [NUM_IN-1:0]                maskQ,
  input logic [NUM_IN-1:0]                statusQ,
  input logic [NUM_ROUTE_REGS*DATA_W-1:0] routeFlat,
  input logic [NUM_OUT-1:0]               irqOut
);
  logic inMap;
  assign inMap = (regAddr == ADDR_W'(0)) || (regAddr == ADDR_W'(4)) ||
                 ((regAddr[1:0] == 2'b00) && (regAddr >= ADDR_W'(8)) &&
                  (regAddr < ADDR_W'(8 + 4 * NUM_ROUTE_REGS)));

  p_mask_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(0)) |=> (maskQ == $past(regWdata[NUM_IN-1:0])));

  p_status_write_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(4)) |=> ($stable(maskQ) && $stable(routeFlat)));

  p_no_route_no_out_r6: assert property (@(posedge clk) disable iff (!rstN)
    (routeFlat == '0) |=> (irqOut == '0));

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    (maskQ == '0) |=> (irqOut == '0));

  p_out_has_source_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|irqOut) |-> $past(|(statusQ & maskQ)));

  p_unmapped_write_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && !inMap) |=> ($stable(maskQ) && $stable(routeFlat)));
endmodule

bind irq_route_ctrl irq_route_checker #(
  .NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
  .NUM_ROUTE_REGS(NUM_ROUTE_REGS)
) u_chk (
  .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
  .regWdata(regWdata), .maskQ(maskQ), .statusQ(statusQ),
  .routeFlat(routeFlat), .irqOut(irqOut)
);

// File: tb/sim_irq_route_ctrl.sv
module sim_irq_route_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rstN = 0;
  logic [31:0] irqIn = '0;
  logic        regWe = 0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [14:0] irqOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_route_ctrl u0 (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] mSync, mStat, mMask;
  logic [31:0] mRoute [4];
  logic [14:0] mOut;

  function automatic int codeFor(input int n);
    int word = 3 - n / 8;
    return int'((mRoute[word] >> ((n % 8) * 4)) & 32'hF);
  endfunction

  function automatic logic [14:0] calcOut();
    logic [14:0] o = '0;
    for (int n = 0; n < 32; n++) begin
      int c = codeFor(n);
      if (c != 0 && mStat[n] && mMask[n]) o[c-1] = 1'b1;
    end
    return o;
  endfunction

  function automatic logic [31:0] mRead(input logic [7:0] a);
    case (a)
      8'h00: return mMask;
      8'h04: return mStat;
      8'h08: return mRoute[0];
      8'h0C: return mRoute[1];
      8'h10: return mRoute[2];
      8'h14: return mRoute[3];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagFor(input logic [7:0] a);
    case (a)
      8'h00: return "R2";
      8'h04: return "R3";
      8'h08, 8'h0C, 8'h10, 8'h14: return "R4";
      default: return "R10";
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mSync <= '0; mStat <= '0; mMask <= '0; mOut <= '0;
      for (int i = 0; i < 4; i++) mRoute[i] <= '0;
    end else begin
      mSync <= irqIn;
      mStat <= mSync;
      mOut  <= calcOut();
      if (regWe) begin
        case (regAddr)
          8'h00: mMask <= regWdata;
          8'h08: mRoute[0] <= regWdata;
          8'h0C: mRoute[1] <= regWdata;
          8'h10: mRoute[2] <= regWdata;
          8'h14: mRoute[3] <= regWdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model (R9 for outputs)
  always @(posedge clk) begin
    #2;
    if (rstN && !done) begin
      check("R9", {17'h0, irqOut}, {17'h0, mOut});
      check(tagFor(regAddr), regRdata, mRead(regAddr));
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1;
    check(tag, regRdata, exp);
  endtask

  task automatic setIn(input logic [31:0] v);
    @(negedge clk);
    irqIn = v;
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    tick(1);
    check("R1", {17'h0, irqOut}, 32'h0);
    rdChk("R1", 8'h00, 32'h0);
    rdChk("R1", 8'h08, 32'h0);
    rdChk("R1", 8'h14, 32'h0);

    // R2 mask store
    wr(8'h00, 32'hFFFF_FFFF);
    rdChk("R2", 8'h00, 32'hFFFF_FFFF);

    // R3 status read-only and synchronized
    wr(8'h04, 32'h1234_5678);
    rdChk("R3", 8'h04, 32'h0);
    rdChk("R3", 8'h00, 32'hFFFF_FFFF);

    // R5 placement: input 0 at 0x14 bits[3:0]=1, input 31 at 0x08 bits[31:28]=15
    wr(8'h14, 32'h0000_0001);
    wr(8'h08, 32'hF000_0000);
    rdChk("R4", 8'h08, 32'hF000_0000);
    setIn(32'h0000_0001);
    tick(2);
    check("R9", {17'h0, irqOut}, 32'h0);
    check("R3", regRdata & 0, 32'h0);
    tick(1);
    check("R5", {17'h0, irqOut}, 32'h0000_0001);
    rdChk("R3", 8'h04, 32'h0000_0001);

    // R6 code 15 reaches output 14
    setIn(32'h8000_0001);
    tick(3);
    check("R6", {17'h0, irqOut}, 32'h0000_4001);

    // R6 code 0 disconnected: input 5 has code 0
    setIn(32'h0000_0020);
    tick(3);
    check("R6", {17'h0, irqOut}, 32'h0);

    // R7 mask gating with one-edge latency
    setIn(32'h0000_0001);
    tick(3);
    check("R7", {17'h0, irqOut}, 32'h0000_0001);
    wr(8'h00, 32'hFFFF_FFFE);
    tick(1);
    check("R7", {17'h0, irqOut}, 32'h0);

    // R8 two sources (inputs 8, 9) share output 2 via code 3 at 0x10
    wr(8'h10, 32'h0000_0033);
    setIn(32'h0000_0300);
    tick(3);
    check("R8", {17'h0, irqOut}, 32'h0000_0004);
    setIn(32'h0000_0200);
    tick(3);
    check("R8", {17'h0, irqOut}, 32'h0000_0004);
    setIn(32'h0000_0000);
    tick(3);
    check("R8", {17'h0, irqOut}, 32'h0);

    // R10 unmapped and unaligned offsets
    wr(8'h18, 32'hDEAD_BEEF);
    wr(8'h02, 32'h0000_0000);
    wr(8'h09, 32'h0000_0000);
    rdChk("R10", 8'h18, 32'h0);
    rdChk("R10", 8'h0A, 32'h0);
    rdChk("R10", 8'h00, 32'hFFFF_FFFE);
    rdChk("R10", 8'h08, 32'hF000_0000);

    // mixed traffic against the model
    lfsr = 32'hACE1_1234;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      irqIn = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      regWe = (lfsr[3:2] == 2'b00);
      case (lfsr[6:4])
        3'd0: regAddr = 8'h00;
        3'd1: regAddr = 8'h04;
        3'd2: regAddr = 8'h08;
        3'd3: regAddr = 8'h0C;
        3'd4: regAddr = 8'h10;
        3'd5: regAddr = 8'h14;
        3'd6: regAddr = 8'h18;
        default: regAddr = 8'h06;
      endcase
      regWdata = {lfsr[7:0], lfsr[31:8]};
    end
    @(negedge clk);
    regWe = 0;
    tick(4);
    finishRun();
  end
endmodule